// File: doc/BRIEF.md
# Processor Address and Program Counter Generator

This block produces the 16-bit memory address for every cycle of a small 16-bit processor. The address can come from an instruction fetch, a load or store, or a DMA transfer. The program counter is not a lone register. It is entry 0 of a 16-entry by 16-bit register file, and entry 1 of the same file holds the DMA address pointer.

One adder serves every path. It adds either the constant 2 or a doubled, sign-extended 8-bit branch displacement to the selected register-file entry. An address mux then picks one of four sources:

- the adder result;
- the effective-address sum supplied by an external adder/subtractor;
- the raw DMA pointer;
- zero, used during reset.

A write enable decides whether the register file takes a new value at the clock edge.

The address output is combinational and valid in the cycle the access type is presented. The program counter output shows entry 0, which updates at the following rising edge.

The access type is a 2-bit code: 00 is an instruction fetch, 01 is a load/store, 10 is a DMA access and 11 is treated exactly like a load/store.

Top module: `addr_pc_gen`

## Requirements
- R1: While `rst` is 1, `mem_addr` is 0. After a rising edge with `rst` at 1, `cpu_pc` is 0 and the DMA pointer (entry 1) is 0.
- R2: On a fetch (`acc_kind`=00) with `jump`=0 and `br_taken`=0, `mem_addr` is `cpu_pc`+2, and `cpu_pc` takes that value at the next edge.
- R3: On a fetch with `br_taken`=1 and `jump`=0, `mem_addr` is `cpu_pc` plus twice the sign-extended `br_disp`, modulo 2^16, and `cpu_pc` takes that value at the next edge.
- R4: On a fetch with `jump`=1, `mem_addr` is `ea_sum` and `cpu_pc` takes `ea_sum` at the next edge, whatever the value of `br_taken`.
- R5: On a load/store (`acc_kind`=01), `mem_addr` is `ea_sum` and `cpu_pc` is unchanged. `jump` and `br_taken` have no effect.
- R6: On a DMA access (`acc_kind`=10), `mem_addr` is the DMA pointer. The pointer advances by 2 at the next edge and `cpu_pc` is unchanged.
- R7: `acc_kind`=11 behaves exactly as a load/store: `mem_addr` is `ea_sum` and neither `cpu_pc` nor the DMA pointer changes.
- R8: Increments wrap modulo 2^16. For example, a fetch at `cpu_pc`=0xFFFE addresses 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_kind | input | 2 | Access type: 00 fetch, 01 load/store, 10 DMA, 11 as load/store |
| br_taken | input | 1 | Branch taken on this fetch |
| br_disp | input | 8 | Signed branch displacement, in instruction words |
| jump | input | 1 | Jump or call on this fetch |
| ea_sum | input | 16 | Effective-address sum from the external adder/subtractor |
| mem_addr | output | 16 | Memory address for this cycle |
| cpu_pc | output | 16 | Current CPU program counter (register-file entry 0) |

## Verification
The bench targets four kinds of corner case:

- **Negative displacements, including -128.** A design that zero-extends the displacement would jump forward by up to 510 bytes instead of going back.
- **Address wrap at 0xFFFE.** A design that mishandles it would lose or saturate the carry.
- **Jump and branch flags raised during load/store, DMA and the unused code 11.** A design that decodes those flags without the access type would corrupt the program counter during data accesses.
- **DMA pointer isolation.** DMA accesses are interleaved with fetches, which would show any design that updates the wrong register-file entry or reads the program counter as the DMA address.

A reset issued mid-run checks that both the program counter and the DMA pointer return to 0.

// File: rtl/addr_pc_gen.sv
module addr_pc_gen #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ENTRIES = 16,
  parameter int DMA_IDX = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    acc_kind,
  input  logic          br_taken,
  input  logic [DW-1:0] br_disp,
  input  logic          jump,
  input  logic [AW-1:0] ea_sum,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] cpu_pc
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_DMA   = 2'b10;

  logic [AW-1:0] rf [ENTRIES];

  wire is_fetch = (acc_kind == K_FETCH);
  wire is_dma   = (acc_kind == K_DMA);

  wire [IW-1:0] idx      = is_dma ? IW'(DMA_IDX) : '0;
  wire [AW-1:0] base     = rf[idx];
  wire [AW-1:0] disp2    = {{(AW-DW-1){br_disp[DW-1]}}, br_disp, 1'b0};
  wire [AW-1:0] incr     = (is_fetch && br_taken) ? disp2 : AW'(2);
  wire [AW-1:0] pc_next  = base + incr;
  wire          take_ea  = is_fetch && jump;
  wire          wr_en    = is_fetch || is_dma;
  wire [AW-1:0] wr_data  = take_ea ? ea_sum : pc_next;

  always_comb begin
    if (rst)                     mem_addr = '0;
    else if (is_dma)             mem_addr = base;
    else if (is_fetch && !jump)  mem_addr = pc_next;
    else                         mem_addr = ea_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[idx] <= wr_data;
    end
  end

  assign cpu_pc = rf[0];
endmodule

module addr_pc_gen_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    acc_kind,
  input logic          br_taken,
  input logic [DW-1:0] br_disp,
  input logic          jump,
  input logic [AW-1:0] ea_sum,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] cpu_pc
);
  // R1
  reset_addr_zero_chk: assert property (@(posedge clk) rst |-> mem_addr == '0);
  // R1
  reset_pc_zero_chk: assert property (@(posedge clk) rst |=> cpu_pc == '0);
  // R2
  fetch_pc_follows_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b00) |=> cpu_pc == $past(mem_addr));
  // R4
  jump_addr_is_ea_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b00 && jump) |-> mem_addr == ea_sum);
  // R5
  data_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc_kind[0] |=> cpu_pc == $past(cpu_pc));
  // R7
  data_addr_is_ea_chk: assert property (@(posedge clk) disable iff (rst)
    acc_kind[0] |-> mem_addr == ea_sum);
  // R6
  dma_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b10) |=> cpu_pc == $past(cpu_pc));
endmodule

bind addr_pc_gen addr_pc_gen_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_addr_pc_gen.sv
module test_addr_pc_gen;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  acc_kind = 2'b01;
  logic        br_taken = 0;
  logic [7:0]  br_disp = '0;
  logic        jump = 0;
  logic [15:0] ea_sum = '0;
  logic [15:0] mem_addr, cpu_pc;

  addr_pc_gen i_addr_pc_gen (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [15:0] addr;
    logic [15:0] pc;
    bit          pc_known;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_pc = '0, m_dma = '0;
  bit m_known = 0;
  bit done = 0;

  task automatic step(input logic r, input logic [1:0] k, input logic tk,
                      input logic [7:0] d, input logic j, input logic [15:0] ea,
                      input string tag);
    item_t it;
    logic [15:0] a;
    @(negedge clk);
    rst = r; acc_kind = k; br_taken = tk; br_disp = d; jump = j; ea_sum = ea;
    if (r) a = 16'h0;
    else if (k == 2'b10) a = m_dma;
    else if (k == 2'b00 && j) a = ea;
    else if (k == 2'b00 && tk) a = m_pc + {{7{d[7]}}, d, 1'b0};
    else if (k == 2'b00) a = m_pc + 16'd2;
    else a = ea;
    it.addr = a; it.pc = m_pc; it.pc_known = m_known; it.tag = tag;
    q.push_back(it);
    if (r) begin m_pc = 0; m_dma = 0; m_known = 1; end
    else if (k == 2'b00) m_pc = a;
    else if (k == 2'b10) m_dma = m_dma + 16'd2;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_cmp++;
        if (mem_addr !== it.addr) begin
          n_bad++;
          $display("FAIL %s mem_addr actual=%h expected=%h", it.tag, mem_addr, it.addr);
        end
        if (it.pc_known) begin
          n_cmp++;
          if (cpu_pc !== it.pc) begin
            n_bad++;
            $display("FAIL %s cpu_pc actual=%h expected=%h", it.tag, cpu_pc, it.pc);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    step(1, 2'b01, 0, 8'h00, 0, 16'h0,    "R1 reset");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R2 fetch");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R2 fetch");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R2 fetch");
    step(0, 2'b00, 1, 8'h05, 0, 16'h0,    "R3 branch fwd");
    step(0, 2'b00, 1, 8'hFD, 0, 16'h0,    "R3 branch back");
    step(0, 2'b01, 1, 8'h10, 1, 16'h1234, "R5 load/store");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R5 pc kept");
    step(0, 2'b00, 1, 8'h33, 1, 16'h8000, "R4 jump over branch");
    step(0, 2'b10, 1, 8'h40, 1, 16'hBEEF, "R6 dma");
    step(0, 2'b10, 0, 8'h00, 0, 16'h0,    "R6 dma");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R6 pc after dma");
    step(0, 2'b11, 1, 8'h22, 1, 16'h55AA, "R7 code 11");
    step(0, 2'b10, 0, 8'h00, 0, 16'h0,    "R7 dma ptr kept");
    step(0, 2'b00, 1, 8'h80, 0, 16'h0,    "R3 branch -128");
    step(0, 2'b00, 0, 8'h00, 1, 16'hFFFE, "R4 jump");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R8 wrap");
    step(0, 2'b00, 1, 8'hFF, 0, 16'h0,    "R8 wrap back");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R2 fetch");
    step(1, 2'b00, 1, 8'h11, 1, 16'h7777, "R1 reset mid-run");
    step(0, 2'b10, 0, 8'h00, 0, 16'h0,    "R1 dma ptr cleared");
    step(0, 2'b00, 0, 8'h00, 0, 16'h0,    "R1 pc cleared");
    step(0, 2'b01, 0, 8'h00, 0, 16'hA5A5, "R5 load/store");
    @(negedge clk);
    rst = 0; acc_kind = 2'b01;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule